// File: doc/BRIEF.md
# ASID-Tagged Set-Associative Translation Lookup

This block is the lookup stage of a set-associative translation buffer for fixed 4 KiB pages. Every way is a small array of entries. Each entry stores a virtual page number, an 8-bit address-space identifier, a physical page number and a 4-bit attribute. A request presents a virtual address, a data-or-instruction flag and the current privilege ring. All ways are indexed by the low page-number bits at the same time and their tags are compared. One cycle later the block returns a registered response. The response carries the hit way, the entry index, the ring the entry belongs to, the translated address, the attribute, a fault cause and a probe word.

Rings are resolved through a ring-identifier register. The register holds one identifier byte for each of four rings. An entry belongs to the most privileged ring whose byte equals the entry's identifier. Entries are loaded with a write request that picks the identifier from that register. An invalidate request clears the identifier of one entry, which makes the entry unmatchable.

Top module: `asid_tlb`

## Requirements
- R1: An entry is selected by index bits 13:12 of the virtual address (default geometry). It matches only if its stored page number equals address bits 31:12 and its identifier is nonzero.
- R2: The ring-identifier register resets to 0x04030201. A write loads bits 31:8 from the write data and forces bits 7:0 to 0x01.
- R3: Byte n of the ring-identifier register (bits 8n+7:8n) belongs to ring n. An entry's ring is the lowest n whose byte equals the entry identifier. If no byte matches, the entry's ring is 3.
- R4: Exactly one matching way gives rsp_hit=1, the way, the ring, the address {ppn, vaddr[11:0]}, the attribute and cause 0. Two or more matches give cause 17 (instruction) or 25 (data). No match gives cause 16 (instruction) or 24 (data). In both fault cases rsp_hit=0, and way, ring, address and attribute are zero.
- R5: A single hit whose ring is numerically below the request ring gives cause 18 (instruction) or 26 (data).
- R6: rsp_valid is high in exactly the cycle after a cycle with lk_req high, and is low otherwise. rsp_index always carries the request index bits.
- R7: rsp_probe is {vaddr[31:12], 12'b0} OR the way number OR 0x10 for data or 0x08 for instruction. This applies only to a single hit whose ring is at or above the request ring. Otherwise rsp_probe is zero.
- R8: After reset every entry has identifier 0, so every lookup misses.
- R9: An entry write stores the page number into the selected way at the index taken from that page number. It takes the identifier from the ring-identifier byte selected by ent_asid_sel (a PTE's bits 5:4), and stores the attribute and physical page. Lookups issued from the next cycle on see the new entry.
- R10: An invalidate clears the identifier of the addressed entry. A write to the same entry in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rasid_we | input | 1 | Ring-identifier register write strobe |
| rasid_wupper | input | 24 | New identifiers for rings 3..1 (register bits 31:8) |
| rasid_q | output | 32 | Ring-identifier register contents |
| ent_we | input | 1 | Entry write strobe |
| ent_way | input | 2 | Way to write |
| ent_vpn | input | 20 | Virtual page number to store (low bits pick the index) |
| ent_ppn | input | 20 | Physical page number to store |
| ent_asid_sel | input | 2 | Ring whose identifier byte the entry takes |
| ent_attr | input | 4 | Attribute to store |
| inv_req | input | 1 | Invalidate strobe |
| inv_way | input | 2 | Way to invalidate |
| inv_idx | input | 2 | Entry index to invalidate |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_data | input | 1 | 1 for a data access, 0 for an instruction fetch |
| lk_ring | input | 2 | Current privilege ring |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | Exactly one way matched |
| rsp_way | output | 2 | Matching way |
| rsp_index | output | 2 | Entry index of the request |
| rsp_ring | output | 2 | Ring of the matching entry |
| rsp_paddr | output | 32 | Translated address |
| rsp_attr | output | 4 | Entry attribute |
| rsp_cause | output | 6 | Fault cause, 0 if none |
| rsp_probe | output | 32 | Probe word |

## Verification
The bench targets several corner cases:
- A page tagged in two ways must report the multi-hit code and not pick one of the ways; a design that prioritised a way would return a clean hit.
- An identifier shared by two rings must resolve to the lower ring. After the register is rewritten, an identifier present in no byte must resolve to ring 3; a highest-match or default-0 design would report a different ring and a wrong privilege verdict.
- The privilege boundary is probed with the entry ring equal to the request ring (no fault) and one below (fault). An off-by-one comparison flips one of these.
- Write-over-invalidate on one entry, and a write that reads the selected register byte rather than the low one, are both checked through later lookups.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
  localparam int VA_W   = 32;
  localparam int PG_OFF = 12;
  localparam int VPN_W  = VA_W - PG_OFF;

  localparam logic [5:0] CAUSE_NONE    = 6'd0;
  localparam logic [5:0] CAUSE_I_MISS  = 6'd16;
  localparam logic [5:0] CAUSE_I_MULTI = 6'd17;
  localparam logic [5:0] CAUSE_I_PRIV  = 6'd18;
  localparam logic [5:0] CAUSE_D_MISS  = 6'd24;
  localparam logic [5:0] CAUSE_D_MULTI = 6'd25;
  localparam logic [5:0] CAUSE_D_PRIV  = 6'd26;

  localparam logic [31:0] RASID_RESET = 32'h0403_0201;

  // Most privileged ring whose identifier byte equals the given identifier.
  function automatic logic [1:0] ring_of(input logic [7:0] asid, input logic [31:0] rasid);
    logic [1:0] r;
    r = 2'd3;
    for (int n = 3; n >= 0; n--) begin
      if (rasid[8*n +: 8] == asid) r = 2'(n);
    end
    return r;
  endfunction

  function automatic logic [7:0] asid_pick(input logic [31:0] rasid, input logic [1:0] sel);
    return rasid[8*sel +: 8];
  endfunction

  function automatic logic [31:0] probe_word(input logic [VA_W-1:0] va, input logic [2:0] way,
                                             input logic is_data);
    return {va[VA_W-1:PG_OFF], {PG_OFF{1'b0}}} | {29'd0, way} | (is_data ? 32'h10 : 32'h08);
  endfunction
endpackage

// File: rtl/asid_tlb_way.sv
module asid_tlb_way #(
  parameter int IDX_BITS = 2,
  parameter int VPN_W    = 20,
  parameter int PPN_W    = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [VPN_W-1:0]    wr_vpn,
  input  logic [7:0]          wr_asid,
  input  logic [PPN_W-1:0]    wr_ppn,
  input  logic [3:0]          wr_attr,
  input  logic                inv_en,
  input  logic [IDX_BITS-1:0] inv_idx,
  input  logic [VPN_W-1:0]    lk_vpn,
  output logic                lk_match,
  output logic [7:0]          lk_asid,
  output logic [PPN_W-1:0]    lk_ppn,
  output logic [3:0]          lk_attr
);
  localparam int DEPTH = 1 << IDX_BITS;

  logic [VPN_W-1:0] vpn_q  [DEPTH];
  logic [7:0]       asid_q [DEPTH];
  logic [PPN_W-1:0] ppn_q  [DEPTH];
  logic [3:0]       attr_q [DEPTH];

  logic [IDX_BITS-1:0] wr_idx, lk_idx;
  assign wr_idx = wr_vpn[IDX_BITS-1:0];
  assign lk_idx = lk_vpn[IDX_BITS-1:0];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vpn_q[e]  <= '0;
        asid_q[e] <= 8'd0;
        ppn_q[e]  <= '0;
        attr_q[e] <= 4'd0;
      end else if (wr_en && wr_idx == IDX_BITS'(e)) begin
        vpn_q[e]  <= wr_vpn;
        asid_q[e] <= wr_asid;
        ppn_q[e]  <= wr_ppn;
        attr_q[e] <= wr_attr;
      end else if (inv_en && inv_idx == IDX_BITS'(e)) begin
        asid_q[e] <= 8'd0;
      end
    end
  end

  assign lk_asid  = asid_q[lk_idx];
  assign lk_ppn   = ppn_q[lk_idx];
  assign lk_attr  = attr_q[lk_idx];
  assign lk_match = (vpn_q[lk_idx] == lk_vpn) && (asid_q[lk_idx] != 8'd0);

  // R10: an invalidate not overridden by a write leaves the entry unmatchable
  a_r10_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && !(wr_en && wr_idx == inv_idx)) |=> asid_q[$past(inv_idx)] == 8'd0);

  // R9: a write lands in the entry its page number indexes
  a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (vpn_q[$past(wr_idx)] == $past(wr_vpn)) && (asid_q[$past(wr_idx)] == $past(wr_asid)));
endmodule

// File: rtl/asid_tlb_resolve.sv
module asid_tlb_resolve
  import asid_tlb_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int WAY_W    = 2
) (
  input  logic [NUM_WAYS-1:0]      match,
  input  logic [NUM_WAYS-1:0][7:0] asid,
  input  logic [31:0]              rasid,
  output logic                     one_hit,
  output logic                     multi_hit,
  output logic [WAY_W-1:0]         hit_way,
  output logic [1:0]               hit_ring
);
  localparam int CNT_W = $clog2(NUM_WAYS + 1);

  logic [CNT_W-1:0] cnt;
  logic [WAY_W-1:0] first;

  always_comb begin
    cnt   = '0;
    first = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--) begin
      if (match[i]) begin
        cnt   = cnt + CNT_W'(1);
        first = WAY_W'(i);
      end
    end
  end

  assign one_hit   = (cnt == CNT_W'(1));
  assign multi_hit = (cnt > CNT_W'(1));
  assign hit_way   = first;
  assign hit_ring  = ring_of(asid[first], rasid);
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int IDX_BITS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rasid_we,
  input  logic [23:0]         rasid_wupper,
  output logic [31:0]         rasid_q,
  input  logic                ent_we,
  input  logic [1:0]          ent_way,
  input  logic [19:0]         ent_vpn,
  input  logic [19:0]         ent_ppn,
  input  logic [1:0]          ent_asid_sel,
  input  logic [3:0]          ent_attr,
  input  logic                inv_req,
  input  logic [1:0]          inv_way,
  input  logic [IDX_BITS-1:0] inv_idx,
  input  logic                lk_req,
  input  logic [31:0]         lk_vaddr,
  input  logic                lk_data,
  input  logic [1:0]          lk_ring,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic [1:0]          rsp_way,
  output logic [IDX_BITS-1:0] rsp_index,
  output logic [1:0]          rsp_ring,
  output logic [31:0]         rsp_paddr,
  output logic [3:0]          rsp_attr,
  output logic [5:0]          rsp_cause,
  output logic [31:0]         rsp_probe
);
  localparam int WAY_W = 2;

  // ring-identifier register
  always_ff @(posedge clk) begin
    if (!rst_n)        rasid_q <= RASID_RESET;
    else if (rasid_we) rasid_q <= {rasid_wupper, 8'h01};
  end

  logic [7:0] wr_asid;
  assign wr_asid = asid_pick(rasid_q, ent_asid_sel);

  logic [VPN_W-1:0] lk_vpn;
  assign lk_vpn = lk_vaddr[VA_W-1:PG_OFF];

  logic [NUM_WAYS-1:0]            way_match;
  logic [NUM_WAYS-1:0][7:0]       way_asid;
  logic [NUM_WAYS-1:0][VPN_W-1:0] way_ppn;
  logic [NUM_WAYS-1:0][3:0]       way_attr;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    asid_tlb_way #(.IDX_BITS(IDX_BITS), .VPN_W(VPN_W), .PPN_W(VPN_W)) u_way (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ent_we && ent_way == WAY_W'(w)),
      .wr_vpn  (ent_vpn),
      .wr_asid (wr_asid),
      .wr_ppn  (ent_ppn),
      .wr_attr (ent_attr),
      .inv_en  (inv_req && inv_way == WAY_W'(w)),
      .inv_idx (inv_idx),
      .lk_vpn  (lk_vpn),
      .lk_match(way_match[w]),
      .lk_asid (way_asid[w]),
      .lk_ppn  (way_ppn[w]),
      .lk_attr (way_attr[w])
    );
  end

  logic             one_hit, multi_hit;
  logic [WAY_W-1:0] hit_way;
  logic [1:0]       hit_ring;

  asid_tlb_resolve #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_res (
    .match    (way_match),
    .asid     (way_asid),
    .rasid    (rasid_q),
    .one_hit  (one_hit),
    .multi_hit(multi_hit),
    .hit_way  (hit_way),
    .hit_ring (hit_ring)
  );

  logic       priv_fault;
  logic [5:0] n_cause;
  assign priv_fault = one_hit && (hit_ring < lk_ring);

  always_comb begin
    if (multi_hit)     n_cause = lk_data ? CAUSE_D_MULTI : CAUSE_I_MULTI;
    else if (!one_hit) n_cause = lk_data ? CAUSE_D_MISS  : CAUSE_I_MISS;
    else if (priv_fault) n_cause = lk_data ? CAUSE_D_PRIV : CAUSE_I_PRIV;
    else               n_cause = CAUSE_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_way   <= '0;
      rsp_index <= '0;
      rsp_ring  <= '0;
      rsp_paddr <= '0;
      rsp_attr  <= '0;
      rsp_cause <= CAUSE_NONE;
      rsp_probe <= '0;
    end else begin
      rsp_valid <= lk_req;
      if (lk_req) begin
        rsp_hit   <= one_hit;
        rsp_index <= lk_vaddr[PG_OFF +: IDX_BITS];
        rsp_cause <= n_cause;
        rsp_way   <= one_hit ? hit_way : '0;
        rsp_ring  <= one_hit ? hit_ring : 2'd0;
        rsp_paddr <= one_hit ? {way_ppn[hit_way], lk_vaddr[PG_OFF-1:0]} : '0;
        rsp_attr  <= one_hit ? way_attr[hit_way] : 4'd0;
        rsp_probe <= (one_hit && !priv_fault) ? probe_word(lk_vaddr, 3'(hit_way), lk_data) : '0;
      end
    end
  end

  // R2: a register write keeps the upper bytes and pins the low byte
  a_r2_rasid_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    rasid_we |=> rasid_q == {$past(rasid_wupper), 8'h01});

  // R6: one response per request, one cycle later
  a_r6_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_valid);
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !rsp_valid);

  // R4: the reported single way really matched
  a_r4_way_matched: assert property (@(posedge clk) disable iff (!rst_n)
    one_hit |-> way_match[hit_way]);

  // R5: a privilege fault always comes from a hit below the request ring
  a_r5_priv_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_cause == CAUSE_I_PRIV || rsp_cause == CAUSE_D_PRIV))
      |-> (rsp_hit && rsp_ring < $past(lk_ring)));

  // R7: a probe word appears only with a clean hit
  a_r7_probe_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_probe != 32'd0) |-> (rsp_hit && rsp_cause == CAUSE_NONE));
endmodule

// File: tb/sim_asid_tlb.sv
module sim_asid_tlb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        rasid_we;
  logic [23:0] rasid_wupper;
  logic [31:0] rasid_q;
  logic        ent_we;
  logic [1:0]  ent_way;
  logic [19:0] ent_vpn, ent_ppn;
  logic [1:0]  ent_asid_sel;
  logic [3:0]  ent_attr;
  logic        inv_req;
  logic [1:0]  inv_way, inv_idx;
  logic        lk_req;
  logic [31:0] lk_vaddr;
  logic        lk_data;
  logic [1:0]  lk_ring;
  logic        rsp_valid, rsp_hit;
  logic [1:0]  rsp_way, rsp_index, rsp_ring;
  logic [31:0] rsp_paddr, rsp_probe;
  logic [3:0]  rsp_attr;
  logic [5:0]  rsp_cause;

  asid_tlb u0 (.*);

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model state
  logic [19:0] m_vpn  [0:3][0:3];
  logic [7:0]  m_asid [0:3][0:3];
  logic [19:0] m_ppn  [0:3][0:3];
  logic [3:0]  m_attr [0:3][0:3];
  logic [31:0] m_rasid;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // every clock: response valid follows the previous cycle's request (R6)
  always @(posedge clk) begin
    automatic logic prev = lk_req;
    automatic logic live = rst_n;
    #5;
    if (live && !done) check("R6 rsp_valid", {31'd0, rsp_valid}, {31'd0, prev});
  end

  task automatic set_rasid(input logic [31:0] v);
    @(negedge clk); rasid_we = 1'b1; rasid_wupper = v[31:8];
    @(negedge clk); rasid_we = 1'b0;
    m_rasid = {v[31:8], 8'h01};
    check("R2 rasid", rasid_q, m_rasid);
  endtask

  task automatic put(input int way, input logic [31:0] va, input logic [31:0] pte, input bit also_inv);
    automatic int idx = int'(va[13:12]);
    @(negedge clk);
    ent_we = 1'b1; ent_way = 2'(way); ent_vpn = va[31:12];
    ent_ppn = pte[31:12]; ent_asid_sel = pte[5:4]; ent_attr = pte[3:0];
    inv_req = also_inv; inv_way = 2'(way); inv_idx = 2'(idx);
    @(negedge clk);
    ent_we = 1'b0; inv_req = 1'b0;
    m_vpn[way][idx]  = va[31:12];
    m_asid[way][idx] = m_rasid[8*pte[5:4] +: 8];
    m_ppn[way][idx]  = pte[31:12];
    m_attr[way][idx] = pte[3:0];
  endtask

  task automatic kill(input int way, input logic [31:0] va);
    @(negedge clk);
    inv_req = 1'b1; inv_way = 2'(way); inv_idx = va[13:12];
    @(negedge clk);
    inv_req = 1'b0;
    m_asid[way][int'(va[13:12])] = 8'd0;
  endtask

  task automatic look(input string tag, input logic [31:0] va, input bit data, input int ring);
    automatic int idx = int'(va[13:12]);
    automatic int cnt = 0;
    automatic int w1 = 0;
    automatic int er = 3;
    automatic logic [5:0] ec;
    automatic logic [31:0] ep = 32'd0;
    for (int w = 0; w < 4; w++) begin
      if (m_asid[w][idx] != 8'd0 && m_vpn[w][idx] == va[31:12]) begin
        if (cnt == 0) w1 = w;
        cnt++;
      end
    end
    if (cnt == 1) begin
      for (int n = 3; n >= 0; n--) if (m_rasid[8*n +: 8] == m_asid[w1][idx]) er = n;
    end
    if (cnt > 1)           ec = data ? 6'd25 : 6'd17;
    else if (cnt == 0)     ec = data ? 6'd24 : 6'd16;
    else if (er < ring)    ec = data ? 6'd26 : 6'd18;
    else begin
      ec = 6'd0;
      ep = {va[31:12], 12'd0} + 32'(w1) + (data ? 32'h10 : 32'h8);
    end
    @(negedge clk);
    lk_req = 1'b1; lk_vaddr = va; lk_data = data; lk_ring = 2'(ring);
    @(negedge clk);
    lk_req = 1'b0;
    check({tag, " R4 hit"},   {31'd0, rsp_hit}, (cnt == 1) ? 32'd1 : 32'd0);
    check({tag, " R4 cause"}, {26'd0, rsp_cause}, {26'd0, ec});
    check({tag, " R6 index"}, {30'd0, rsp_index}, 32'(idx));
    check({tag, " R7 probe"}, rsp_probe, ep);
    if (cnt == 1) begin
      check({tag, " R3 ring"},  {30'd0, rsp_ring}, 32'(er));
      check({tag, " R4 way"},   {30'd0, rsp_way}, 32'(w1));
      check({tag, " R9 paddr"}, rsp_paddr, {m_ppn[w1][idx], va[11:0]});
      check({tag, " R9 attr"},  {28'd0, rsp_attr}, {28'd0, m_attr[w1][idx]});
    end else begin
      check({tag, " R4 zero fields"}, {rsp_paddr[29:0], rsp_way}, 32'd0);
    end
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rasid_we = 1'b0; rasid_wupper = '0;
    ent_we = 1'b0; ent_way = '0; ent_vpn = '0; ent_ppn = '0; ent_asid_sel = '0; ent_attr = '0;
    inv_req = 1'b0; inv_way = '0; inv_idx = '0;
    lk_req = 1'b0; lk_vaddr = '0; lk_data = 1'b0; lk_ring = '0;
    for (int w = 0; w < 4; w++)
      for (int e = 0; e < 4; e++) begin
        m_vpn[w][e] = '0; m_asid[w][e] = '0; m_ppn[w][e] = '0; m_attr[w][e] = '0;
      end
    m_rasid = 32'h0403_0201;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 and R8: reset state
    check("R2 reset rasid", rasid_q, 32'h0403_0201);
    check("R6 idle", {31'd0, rsp_valid}, 32'd0);
    look("R8 reset miss data", 32'h0000_0000, 1'b1, 0);
    look("R8 reset miss inst", 32'h1234_5678, 1'b0, 0);
    // R2: low byte forced
    set_rasid(32'hAABB_CCDD);
    set_rasid(32'h0403_0299);
    // R1/R4/R9: single hit, pte bits 5:4 = 1 selects identifier 0x02 -> ring 1
    put(0, 32'h1234_5000, 32'h89AB_C013, 1'b0);
    look("R4 hit data", 32'h1234_5ABC, 1'b1, 0);
    look("R7 probe inst", 32'h1234_5004, 1'b0, 1);
    // R5: ring 1 entry, request ring 2 -> privilege fault
    look("R5 priv data", 32'h1234_5000, 1'b1, 2);
    look("R5 priv inst", 32'h1234_5000, 1'b0, 3);
    // R1: same index, different page -> miss
    look("R1 tag mismatch", 32'h1234_9000, 1'b1, 0);
    // R4: multi-hit
    put(2, 32'h1234_5000, 32'h5555_5007, 1'b0);
    look("R4 multi data", 32'h1234_5000, 1'b1, 0);
    look("R4 multi inst", 32'h1234_5000, 1'b0, 0);
    // R10: invalidate way 0, way 2 hits alone
    kill(0, 32'h1234_5000);
    look("R10 after inv", 32'h1234_5FFF, 1'b1, 0);
    // R10: write wins over same-cycle invalidate
    put(1, 32'hFEDC_B000, 32'h0000_1035, 1'b1);
    look("R10 write wins", 32'hFEDC_B123, 1'b0, 3);
    // R3: ring 0 entry and ring boundary
    put(3, 32'h0000_3000, 32'h7777_7001, 1'b0);
    look("R3 ring0", 32'h0000_3010, 1'b1, 0);
    look("R5 ring0 vs 1", 32'h0000_3010, 1'b1, 1);
    // R3: identifier 0x03 (ring 2) orphaned after register rewrite -> ring 3
    put(0, 32'h4444_2000, 32'h2222_2029, 1'b0);
    look("R3 ring2 at 2", 32'h4444_2000, 1'b1, 2);
    set_rasid(32'h0706_0501);
    look("R3 orphan ring3", 32'h4444_2000, 1'b1, 3);
    // R3: duplicate identifier in two bytes -> lowest ring
    set_rasid(32'h0909_0900);
    put(1, 32'h0ABC_D000, 32'h3333_3030, 1'b0);
    look("R3 lowest ring", 32'h0ABC_D000, 1'b0, 1);
    look("R5 lowest ring", 32'h0ABC_D000, 1'b1, 2);
    // R1: entries of identifier 0 never match
    kill(1, 32'h0ABC_D000);
    look("R1 zero asid", 32'h0ABC_D000, 1'b1, 0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule